// File: doc/BRIEF.md
# Triangle Tone Voice

This block is one voice of a sound generator. It produces a 32-step triangle waveform. Each step is a signed amplitude in the range -16 to +16. An 11-bit period timer paces the steps. The voice is gated by two independent counters: a linear counter and a note-length counter. The voice sounds only while both are nonzero and the period is long enough to be heard.

Software programs the voice through three byte-wide registers on a simple write port:

- a control byte holding the hold flag and the linear reload value;
- the low eight period bits;
- a byte holding the high period bits together with a length-table index.

An external frame sequencer supplies a tick strobe that drives both counters.

After a length write, a start gate keeps both counters from counting until a configurable number of ticks has passed with the hold flag clear. While the start gate is still closed, a new control byte reloads the linear counter at once. The amplitude output always holds the last step's value. The mix output reports zero whenever the voice is muted.

Top module: `tri_voice`

## Requirements
- R1: After reset, `amp_out` and `mix_out` are 0 and `len_active` is 0.
- R2: A write to address 3 while `voice_en` is high loads the length counter from a 32-entry table indexed by data bits 7:3, and `len_active` goes high. Index 1 gives 254 and index 3 gives 2.
- R3: While control bit 7 (hold) is set, the start gate does not open and the length counter does not count down on ticks.
- R4: An address 3 write closes the start gate and reloads the linear counter from control bits 6:0. With hold clear, the gate opens on the START_DELAY-th tick (default 1), and that same tick already decrements both counters.
- R5: A control write (address 0) reloads the linear counter from data bits 6:0 immediately while the start gate is closed. Once the gate is open, a control write leaves the linear counter unchanged.
- R6: When the linear counter reaches zero, `mix_out` becomes 0 and the step sequencer freezes, so `amp_out` stays constant.
- R7: Once open, each tick decrements the length counter while hold is clear. When the length counter reaches zero, `len_active` falls, `mix_out` becomes 0 and the sequencer freezes.
- R8: The period is {address 3 bits 2:0, address 2 byte} + 1 clocks per step. A period below 4 mutes the voice and freezes the sequencer.
- R9: At each period expiry a 5-bit step advances and wraps from 31 to 0. The amplitude is 2*step[2:0], replaced by 16 minus that value when step bit 3 is set, and negated when step bit 4 is set.
- R10: While `voice_en` is low, the length and linear counters are cleared and the start gate is closed. Address 3 writes made while disabled do not load the length counter.
- R11: While sounding, `mix_out` equals `amp_out`. While muted, `mix_out` is 0 and `amp_out` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| voice_en | input | 1 | Voice enable level; low clears the counters |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 unused, 2 period low, 3 period high and length index |
| wr_data | input | 8 | Write data |
| frame_tick | input | 1 | Counter tick from the frame sequencer |
| amp_out | output | 6 | Signed amplitude of the current step, held while silent |
| mix_out | output | 6 | Signed amplitude, zero while muted |
| len_active | output | 1 | Length counter is nonzero |

## Verification
The hardest situation to reach is a control write that lands after a length write but before the start gate has opened. That window is only as wide as the ticks the bench chooses to withhold.

The bench works in a fixed order:
1. It loads the length with hold set, which keeps the gate closed indefinitely.
2. It plays the full waveform through the wrap.
3. It clears hold with a small linear value and counts the exact ticks until silence.
4. It repeats the control write after the gate has opened, to show it is ignored.

Length expiry uses the table index that yields 2, so both the open-and-decrement tick and the muting tick are seen at the ports.

// File: rtl/tri_voice_pkg.sv
package tri_voice_pkg;

   localparam int BYTE_W = 8;
   localparam int PER_W  = 11;
   localparam int LIN_W  = 7;
   localparam int LEN_W  = 8;
   localparam int STEP_W = 5;
   localparam int IDX_W  = 5;
   localparam int AMP_W  = 6;

   typedef enum logic [1:0] {
      ADR_CTRL  = 2'd0,
      ADR_SPARE = 2'd1,
      ADR_PLO   = 2'd2,
      ADR_PHI   = 2'd3
   } reg_adr_e;

   // note-length table: odd slots follow a rule, even slots are listed
   function automatic logic [LEN_W-1:0] len_lookup(input logic [IDX_W-1:0] idx);
      logic [LEN_W-1:0] v;
      if (idx[0]) begin
         v = (idx == 5'd1) ? 8'd254 : {3'd0, idx} - 8'd1;
      end else begin
         case (idx[4:1])
            4'd0:  v = 8'd10;
            4'd1:  v = 8'd20;
            4'd2:  v = 8'd40;
            4'd3:  v = 8'd80;
            4'd4:  v = 8'd160;
            4'd5:  v = 8'd60;
            4'd6:  v = 8'd14;
            4'd7:  v = 8'd26;
            4'd8:  v = 8'd12;
            4'd9:  v = 8'd24;
            4'd10: v = 8'd48;
            4'd11: v = 8'd96;
            4'd12: v = 8'd192;
            4'd13: v = 8'd72;
            4'd14: v = 8'd16;
            default: v = 8'd32;
         endcase
      end
      return v;
   endfunction

   // triangle shaping of a 5-bit step into a signed amplitude
   function automatic logic signed [AMP_W-1:0] shape_amp(input logic [STEP_W-1:0] s);
      logic [4:0] mag;
      mag = {1'b0, s[2:0], 1'b0};
      if (s[3]) mag = 5'd16 - mag;
      return s[4] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
   endfunction

endpackage

// File: rtl/tri_regs.sv
module tri_regs
   import tri_voice_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [1:0]          wr_addr,
   input  logic [BYTE_W-1:0]   wr_data,
   output logic [BYTE_W-1:0]   ctrl_q,
   output logic [PER_W-1:0]    period_q,
   output logic                wr_ctrl,
   output logic                wr_len,
   output logic [IDX_W-1:0]    len_idx,
   output logic [LIN_W-1:0]    wr_lin
);
   localparam int HI_W = PER_W - BYTE_W;

   assign wr_ctrl = wr_en && (reg_adr_e'(wr_addr) == ADR_CTRL);
   assign wr_len  = wr_en && (reg_adr_e'(wr_addr) == ADR_PHI);
   assign len_idx = wr_data[BYTE_W-1 -: IDX_W];
   assign wr_lin  = wr_data[LIN_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         period_q <= '0;
      end else if (wr_en) begin
         case (reg_adr_e'(wr_addr))
            ADR_CTRL: ctrl_q <= wr_data;
            ADR_PLO:  period_q[BYTE_W-1:0] <= wr_data;
            ADR_PHI:  period_q[PER_W-1:BYTE_W] <= wr_data[HI_W-1:0];
            default:  ;
         endcase
      end
   end
endmodule

// File: rtl/tri_gate.sv
module tri_gate
   import tri_voice_pkg::*;
#(
   parameter int START_DELAY = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                voice_en,
   input  logic                tick,
   input  logic                hold,
   input  logic [LIN_W-1:0]    lin_reload,
   input  logic                wr_ctrl,
   input  logic [LIN_W-1:0]    wr_lin,
   input  logic                wr_len,
   input  logic [IDX_W-1:0]    len_idx,
   output logic                lin_nz,
   output logic                len_nz
);
   localparam int DLY_W = (START_DELAY < 2) ? 1 : $clog2(START_DELAY + 1);

   logic [LIN_W-1:0] lin_q;
   logic [LEN_W-1:0] len_q;
   logic [DLY_W-1:0] dly_q, dly_next;
   logic             started_q, start_now, counting;

   assign dly_next  = (dly_q == '0) ? '0 : dly_q - 1'b1;
   assign start_now = tick && !started_q && !hold && (dly_next == '0);
   assign counting  = tick && (started_q || start_now);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lin_q     <= '0;
         len_q     <= '0;
         dly_q     <= '0;
         started_q <= 1'b0;
      end else if (!voice_en) begin
         lin_q     <= '0;
         len_q     <= '0;
         dly_q     <= '0;
         started_q <= 1'b0;
      end else if (wr_len) begin
         len_q     <= len_lookup(len_idx);
         lin_q     <= lin_reload;
         dly_q     <= DLY_W'(START_DELAY);
         started_q <= 1'b0;
      end else begin
         if (wr_ctrl && !started_q) begin
            lin_q <= wr_lin;
         end else if (counting && lin_q != '0) begin
            lin_q <= lin_q - 1'b1;
         end
         if (counting && !hold && len_q != '0) begin
            len_q <= len_q - 1'b1;
         end
         if (tick && !started_q && !hold) begin
            dly_q <= dly_next;
            if (start_now) started_q <= 1'b1;
         end
      end
   end

   assign lin_nz = (lin_q != '0);
   assign len_nz = (len_q != '0);

   // R10
   disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !voice_en |=> (!lin_nz && !len_nz && !started_q));
   // R3
   hold_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(started_q) |-> !$past(hold));
   // R2
   len_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_len && voice_en) |=> len_nz);
   // R5
   ctrl_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && started_q && !tick && voice_en) |=> $stable(lin_q));
endmodule

// File: rtl/tri_seq.sv
module tri_seq
   import tri_voice_pkg::*;
#(
   parameter bit OUT_REG = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     gate,
   input  logic [PER_W-1:0]         period,
   output logic signed [AMP_W-1:0]  amp_out,
   output logic signed [AMP_W-1:0]  mix_out
);
   logic [PER_W-1:0]          cnt_q;
   logic [STEP_W-1:0]         step_q;
   logic signed [AMP_W-1:0]   amp_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         step_q <= '0;
      end else if (gate) begin
         if (cnt_q == '0) begin
            cnt_q  <= period;
            step_q <= step_q + 1'b1;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign amp_c = shape_amp(step_q);

   generate
      if (OUT_REG) begin : g_reg_out
         logic signed [AMP_W-1:0] amp_q;
         logic                    gate_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               amp_q  <= '0;
               gate_q <= 1'b0;
            end else begin
               amp_q  <= amp_c;
               gate_q <= gate;
            end
         end
         assign amp_out = amp_q;
         assign mix_out = gate_q ? amp_q : '0;
      end else begin : g_comb_out
         assign amp_out = amp_c;
         assign mix_out = gate ? amp_c : '0;
      end
   endgenerate

   // R6
   freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !gate |=> $stable(step_q));
   // R9
   amp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (amp_out >= -6'sd16) && (amp_out <= 6'sd16));
endmodule

// File: rtl/tri_voice.sv
module tri_voice
   import tri_voice_pkg::*;
#(
   parameter int START_DELAY = 1,
   parameter int MUTE_BELOW  = 4,
   parameter bit OUT_REG     = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     voice_en,
   input  logic                     wr_en,
   input  logic [1:0]               wr_addr,
   input  logic [7:0]               wr_data,
   input  logic                     frame_tick,
   output logic signed [5:0]        amp_out,
   output logic signed [5:0]        mix_out,
   output logic                     len_active
);
   localparam logic [PER_W-1:0] MIN_RAW = PER_W'(MUTE_BELOW - 1);

   generate
      if (START_DELAY < 1 || START_DELAY > 255) begin : g_bad_delay
         $error("tri_voice: START_DELAY out of range");
      end
      if (MUTE_BELOW < 1 || MUTE_BELOW > (1 << PER_W)) begin : g_bad_mute
         $error("tri_voice: MUTE_BELOW out of range");
      end
   endgenerate

   logic [BYTE_W-1:0] ctrl_q;
   logic [PER_W-1:0]  period_q;
   logic              wr_ctrl, wr_len;
   logic [IDX_W-1:0]  len_idx;
   logic [LIN_W-1:0]  wr_lin;
   logic              lin_nz, len_nz, per_ok, gate;

   tri_regs u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .ctrl_q(ctrl_q), .period_q(period_q),
      .wr_ctrl(wr_ctrl), .wr_len(wr_len), .len_idx(len_idx), .wr_lin(wr_lin)
   );

   tri_gate #(.START_DELAY(START_DELAY)) u_gate (
      .clk(clk), .rst_n(rst_n), .voice_en(voice_en), .tick(frame_tick),
      .hold(ctrl_q[BYTE_W-1]), .lin_reload(ctrl_q[LIN_W-1:0]),
      .wr_ctrl(wr_ctrl), .wr_lin(wr_lin), .wr_len(wr_len), .len_idx(len_idx),
      .lin_nz(lin_nz), .len_nz(len_nz)
   );

   assign per_ok = (period_q >= MIN_RAW);
   assign gate   = lin_nz && len_nz && per_ok && voice_en;

   tri_seq #(.OUT_REG(OUT_REG)) u_seq (
      .clk(clk), .rst_n(rst_n), .gate(gate), .period(period_q),
      .amp_out(amp_out), .mix_out(mix_out)
   );

   assign len_active = len_nz;

   // R8
   short_period_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!per_ok && !OUT_REG) |-> (mix_out == '0));
endmodule

// File: tb/tri_voice_tb.sv
module tri_voice_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic voice_en = 1'b0;
   logic wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic frame_tick = 1'b0;
   logic signed [5:0] amp_out, mix_out;
   logic len_active;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   int exp_q[$];
   int exp_gap = 0;
   bit first_of_batch = 1'b1;

   always #10 clk = ~clk;

   tri_voice u_dut (
      .clk(clk), .rst_n(rst_n), .voice_en(voice_en), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .frame_tick(frame_tick),
      .amp_out(amp_out), .mix_out(mix_out), .len_active(len_active)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int model_amp(input int k);
      int s, a;
      s = k % 32;
      a = (s % 8) * 2;
      if (((s / 8) % 2) == 1) a = 16 - a;
      if (s >= 16) a = -a;
      return a;
   endfunction

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic tick();
      frame_tick = 1'b1;
      @(negedge clk);
      frame_tick = 1'b0;
      @(negedge clk);
   endtask

   task automatic push_steps(input int from, input int cnt, input int gap);
      exp_gap = gap;
      first_of_batch = 1'b1;
      for (int k = from; k < from + cnt; k++) exp_q.push_back(model_amp(k));
   endtask

   task automatic drain(input string req);
      int t;
      t = 0;
      while (exp_q.size() > 0 && t < 2000) begin
         @(negedge clk);
         t++;
      end
      chk(req, exp_q.size(), 0);
      exp_q.delete();
   endtask

   task automatic stable_amp(input string req, input int clocks);
      int held;
      held = int'(amp_out);
      repeat (clocks) @(negedge clk);
      chk(req, int'(amp_out), held);
      chk(req, int'(mix_out), 0);
   endtask

   // scoreboard monitor: compare each amplitude change to the queue head
   initial begin : monitor
      int last_amp;
      int last_t;
      int e;
      last_amp = 0;
      last_t = 0;
      forever begin
         @(negedge clk);
         cyc++;
         if (rst_n && int'(amp_out) != last_amp) begin
            if (exp_q.size() > 0) begin
               e = exp_q.pop_front();
               chk("R9 step amplitude", int'(amp_out), e);
               if (!first_of_batch) chk("R8 step period", cyc - last_t, exp_gap);
               first_of_batch = 1'b0;
            end
            last_amp = int'(amp_out);
            last_t = cyc;
         end
      end
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : driver
      int held;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 amp", int'(amp_out), 0);
      chk("R1 mix", int'(mix_out), 0);
      chk("R1 len_active", int'(len_active), 0);
      rst_n = 1'b1;
      @(negedge clk);
      voice_en = 1'b1;
      @(negedge clk);

      // hold set, linear 5, period raw 3 (period 4), length index 1
      wr(2'd0, 8'h85);
      wr(2'd2, 8'h03);
      chk("R11 silent before length", int'(mix_out), 0);
      push_steps(1, 34, 4);
      wr(2'd3, 8'h08);
      chk("R2 len_active after load", int'(len_active), 1);
      drain("R9 full wrap played");

      // slower period, raw 9 -> 10 clocks per step
      wr(2'd2, 8'h09);
      push_steps(35, 4, 10);
      drain("R8 slower period played");

      // R8 short period mutes and freezes
      wr(2'd2, 8'h02);
      stable_amp("R8 short period mute", 30);
      wr(2'd2, 8'h03);
      repeat (6) @(negedge clk);
      chk("R11 mix follows amp", int'(mix_out), int'(amp_out));

      // R3 hold keeps counters still across many ticks
      for (int i = 0; i < 10; i++) tick();
      chk("R3 len_active under hold", int'(len_active), 1);
      repeat (3) @(negedge clk);
      chk("R3 still sounding", int'(mix_out), int'(amp_out));

      // R5 control write before start reloads linear to 3, hold cleared
      wr(2'd0, 8'h03);
      tick();    // R4: gate opens and linear goes 3 -> 2
      tick();    // linear 1
      chk("R4 sounding after two ticks", int'(mix_out), int'(amp_out));
      chk("R4 length still active", int'(len_active), 1);
      tick();    // linear 0
      stable_amp("R6 linear zero mutes", 20);
      chk("R6 length unaffected", int'(len_active), 1);

      // R5 control write after start is ignored
      wr(2'd0, 8'h05);
      stable_amp("R5 ignored after start", 20);

      // R7 length index 3 -> 2; linear reloads 5
      wr(2'd3, 8'h18);
      repeat (6) @(negedge clk);
      chk("R2 reload sounds", int'(mix_out), int'(amp_out));
      tick();
      chk("R7 length one left", int'(len_active), 1);
      tick();
      chk("R7 length expired", int'(len_active), 0);
      stable_amp("R7 length zero mutes", 20);

      // R10 disable clears and blocks length loads
      wr(2'd3, 8'h08);
      chk("R2 load again", int'(len_active), 1);
      repeat (5) @(negedge clk);
      held = int'(amp_out);
      voice_en = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R10 disable clears length", int'(len_active), 0);
      chk("R10 disable mutes", int'(mix_out), 0);
      chk("R11 amp holds on disable", int'(amp_out), held);
      wr(2'd3, 8'h08);
      chk("R10 write while disabled ignored", int'(len_active), 0);
      voice_en = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R10 still empty after enable", int'(len_active), 0);
      chk("R10 still silent", int'(mix_out), 0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule